// File: doc/BRIEF.md
# Time-of-Day Counter with Fractional Increment

This unit keeps a running real-time clock for a network timestamping path. It holds a 48-bit seconds count and a nanoseconds count that stays below one second. On every clock cycle both advance by a programmable step. The step is a whole-nanosecond part plus a 24-bit binary fraction of a nanosecond. The fraction builds up in an accumulator, and each time that accumulator overflows, one extra nanosecond is added. When the nanosecond count reaches one second it wraps, the seconds count goes up by one, and a one-cycle pulse-per-second strobe is raised.

Software reaches the unit through a flat 32-bit write port and a combinational read port. A new step is loaded in two writes: the fraction word is first held in a staging register, and it takes effect together with the whole-nanosecond step when that second register is written. Seconds are also set in two writes. The upper 16 bits go into a shadow register that does not affect the running counter, and the later write of the lower 32 bits loads both halves at once. A signed offset write moves the time forward or backward by a number of nanoseconds once, with carry into or borrow from seconds.

Top module: `tod_clock_unit`

## Requirements
- R1: After reset, seconds, nanoseconds, the fraction accumulator, both step registers and the staging register are zero, and `pps_o` is low.
- R2: While both active step parts are zero and no write occurs, seconds and nanoseconds hold their values.
- R3: A write to address 3 only stages a fraction, unpacked as fraction[23:8] = data[15:0] and fraction[7:0] = data[31:24]. The active step does not change until address 4 is written, and that write makes data[7:0] and the staged fraction active together.
- R4: On each cycle without a load, nanoseconds advance by the active whole step plus the carry out of the 24-bit fraction accumulator, which adds the active fraction.
- R5: When the advanced nanosecond value reaches NS_PER_SEC, NS_PER_SEC is subtracted and seconds increment by one, including a carry across bit 31 into bit 32. The nanosecond output is always below NS_PER_SEC.
- R6: A write to address 0 leaves the running seconds unchanged. A write to address 1 loads seconds with {last address-0 data[15:0], data[31:0]}.
- R7: A write to address 2 loads nanoseconds with data[29:0] and clears the fraction accumulator. No step is applied in that cycle.
- R8: A write to address 5 adds data[29:0] to nanoseconds once when data[31] is 0, and subtracts it when data[31] is 1. The result is brought back into range by a carry into seconds or a borrow from seconds. The step for that cycle is still applied.
- R9: `pps_o` is high for exactly the cycle after a rollover caused by counting alone. It never rises because of a seconds load, a nanoseconds load or an offset.
- R10: `rd_data` shows address 0 as seconds[47:32], address 1 as seconds[31:0], address 2 as nanoseconds, address 3 as the staged fraction repacked in the R3 layout with bits 23:16 zero, address 4 as the active whole step, and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; one step per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| sec_o | output | 48 | Running seconds count |
| ns_o | output | 30 | Running nanoseconds count |
| pps_o | output | 1 | One-cycle strobe on a counting rollover |

## Verification
The bench builds the unit with NS_PER_SEC set to 1000 instead of the default 10^9. With that setting a rollover takes only a few cycles from a preloaded nanosecond value, so wrapping, the pulse-per-second strobe, the carry across the 32-bit seconds boundary and the borrow from seconds on a negative offset can all be reached in a short run. Setting the fraction to one half makes the accumulator carry every second cycle, which lets the check on fractional stepping use exact integer expected values.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int SEC_W        = 48;
    localparam int SEC_HI_W     = 16;
    localparam int SEC_LO_W     = SEC_W - SEC_HI_W;
    localparam int NS_W         = 30;
    localparam int FRAC_W       = 24;
    localparam int INC_NS_W     = 8;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 3;
    localparam int OFF_SIGN_BIT = 31;

    typedef enum logic [ADDR_W-1:0] {
        REG_SEC_HI   = 3'd0,
        REG_SEC_LO   = 3'd1,
        REG_NSEC     = 3'd2,
        REG_INC_FRAC = 3'd3,
        REG_INC_NS   = 3'd4,
        REG_OFFSET   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [SEC_W-1:0]    sec;
        logic [NS_W-1:0]     ns;
        logic [FRAC_W-1:0]   acc;
        logic [SEC_HI_W-1:0] sec_hi;
        logic                pps;
    } tod_state_t;
endpackage

// File: rtl/tod_incr_regs.sv
module tod_incr_regs
    import tod_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frac_wr,
    input  logic                ns_wr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [FRAC_W-1:0]   staged_frac,
    output logic [FRAC_W-1:0]   act_frac,
    output logic [INC_NS_W-1:0] act_ns
);
    localparam int HI_PART = FRAC_W - 8;

    logic [FRAC_W-1:0]   staged_d, staged_q;
    logic [FRAC_W-1:0]   frac_d, frac_q;
    logic [INC_NS_W-1:0] ns_d, ns_q;

    always_comb begin
        staged_d = staged_q;
        frac_d   = frac_q;
        ns_d     = ns_q;
        if (frac_wr) begin
            staged_d = {wr_data[HI_PART-1:0], wr_data[DATA_W-1 -: 8]};
        end
        if (ns_wr) begin
            frac_d = staged_q;
            ns_d   = wr_data[INC_NS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= '0;
            frac_q   <= '0;
            ns_q     <= '0;
        end else begin
            staged_q <= staged_d;
            frac_q   <= frac_d;
            ns_q     <= ns_d;
        end
    end

    assign staged_frac = staged_q;
    assign act_frac    = frac_q;
    assign act_ns      = ns_q;
endmodule

// File: rtl/tod_ns_step.sv
module tod_ns_step
    import tod_pkg::*;
#(
    parameter int unsigned NS_PER_SEC = 1000000000
) (
    input  logic [NS_W-1:0]     ns,
    input  logic [FRAC_W-1:0]   acc,
    input  logic [INC_NS_W-1:0] inc_ns,
    input  logic [FRAC_W-1:0]   inc_frac,
    input  logic                off_en,
    input  logic                off_neg,
    input  logic [NS_W-1:0]     off_mag,
    output logic [NS_W-1:0]     ns_nxt,
    output logic [FRAC_W-1:0]   acc_nxt,
    output logic                sec_up,
    output logic                sec_down
);
    localparam int SW = NS_W + 2;
    localparam logic [SW-1:0] LIMIT = SW'(NS_PER_SEC);

    logic [FRAC_W:0] fsum;
    logic [SW-1:0]   base;
    logic [SW-1:0]   mag;
    logic [SW-1:0]   tmp;

    always_comb begin
        fsum     = {1'b0, acc} + {1'b0, inc_frac};
        base     = SW'(ns) + SW'(inc_ns) + SW'(fsum[FRAC_W]);
        mag      = off_en ? SW'(off_mag) : '0;
        sec_up   = 1'b0;
        sec_down = 1'b0;
        if (off_en && off_neg) begin
            if (mag > base) begin
                tmp      = base + LIMIT - mag;
                sec_down = 1'b1;
            end else begin
                tmp = base - mag;
            end
        end else begin
            tmp = base + mag;
        end
        if (tmp >= LIMIT) begin
            tmp    = tmp - LIMIT;
            sec_up = 1'b1;
        end
        ns_nxt  = tmp[NS_W-1:0];
        acc_nxt = fsum[FRAC_W-1:0];
    end
endmodule

// File: rtl/tod_clock_unit.sv
module tod_clock_unit
    import tod_pkg::*;
#(
    parameter int unsigned NS_PER_SEC = 1000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic [47:0]       sec_o,
    output logic [29:0]       ns_o,
    output logic              pps_o
);
    tod_state_t st_d, st_q;

    logic                frac_wr, incns_wr, off_wr, nsec_wr, seclo_wr, sechi_wr;
    logic [FRAC_W-1:0]   staged_frac, act_frac;
    logic [INC_NS_W-1:0] act_ns;
    logic [NS_W-1:0]     step_ns;
    logic [FRAC_W-1:0]   step_acc;
    logic                step_up, step_down;

    assign sechi_wr = wr_en && (wr_addr == REG_SEC_HI);
    assign seclo_wr = wr_en && (wr_addr == REG_SEC_LO);
    assign nsec_wr  = wr_en && (wr_addr == REG_NSEC);
    assign frac_wr  = wr_en && (wr_addr == REG_INC_FRAC);
    assign incns_wr = wr_en && (wr_addr == REG_INC_NS);
    assign off_wr   = wr_en && (wr_addr == REG_OFFSET);

    tod_incr_regs u_incr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frac_wr     (frac_wr),
        .ns_wr       (incns_wr),
        .wr_data     (wr_data),
        .staged_frac (staged_frac),
        .act_frac    (act_frac),
        .act_ns      (act_ns)
    );

    tod_ns_step #(.NS_PER_SEC(NS_PER_SEC)) u_step (
        .ns       (st_q.ns),
        .acc      (st_q.acc),
        .inc_ns   (act_ns),
        .inc_frac (act_frac),
        .off_en   (off_wr),
        .off_neg  (wr_data[OFF_SIGN_BIT]),
        .off_mag  (wr_data[NS_W-1:0]),
        .ns_nxt   (step_ns),
        .acc_nxt  (step_acc),
        .sec_up   (step_up),
        .sec_down (step_down)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ns  = step_ns;
        st_d.acc = step_acc;
        st_d.pps = step_up && !off_wr;
        if (step_up) begin
            st_d.sec = st_q.sec + SEC_W'(1);
        end else if (step_down) begin
            st_d.sec = st_q.sec - SEC_W'(1);
        end
        if (sechi_wr) begin
            st_d.sec_hi = wr_data[SEC_HI_W-1:0];
        end
        if (nsec_wr) begin
            st_d.ns  = wr_data[NS_W-1:0];
            st_d.acc = '0;
            st_d.sec = st_q.sec;
            st_d.pps = 1'b0;
        end
        if (seclo_wr) begin
            st_d.sec = {st_q.sec_hi, wr_data[SEC_LO_W-1:0]};
            st_d.pps = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (rd_addr)
            REG_SEC_HI:   rd_data = DATA_W'(st_q.sec[SEC_W-1:SEC_LO_W]);
            REG_SEC_LO:   rd_data = st_q.sec[SEC_LO_W-1:0];
            REG_NSEC:     rd_data = DATA_W'(st_q.ns);
            REG_INC_FRAC: rd_data = {staged_frac[7:0], 8'h00, staged_frac[FRAC_W-1:8]};
            REG_INC_NS:   rd_data = DATA_W'(act_ns);
            default:      rd_data = '0;
        endcase
    end

    assign sec_o = st_q.sec;
    assign ns_o  = st_q.ns;
    assign pps_o = st_q.pps;
endmodule

// File: rtl/tod_clock_unit_checker.sv
module tod_clock_unit_checker
    import tod_pkg::*;
#(
    parameter int unsigned NS_PER_SEC = 1000000000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          wr_addr,
    input logic [31:0]         wr_data,
    input logic [47:0]         sec_o,
    input logic [29:0]         ns_o,
    input logic                pps_o,
    input logic [INC_NS_W-1:0] act_ns,
    input logic [FRAC_W-1:0]   act_frac
);
    assert_ns_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ns_o < NS_W'(NS_PER_SEC));

    assert_pps_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pps_o |-> (sec_o == $past(sec_o) + 48'd1));

    assert_pps_counting_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pps_o |-> !$past(wr_en));

    assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && act_ns == '0 && act_frac == '0) |=> ($stable(ns_o) && $stable(sec_o)));

    assert_hi_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_SEC_HI) |=> (pps_o || sec_o == $past(sec_o)));

    assert_ns_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_NSEC && wr_data[NS_W-1:0] < NS_W'(NS_PER_SEC))
        |=> (ns_o == $past(wr_data[NS_W-1:0])));
endmodule

bind tod_clock_unit tod_clock_unit_checker #(.NS_PER_SEC(NS_PER_SEC)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sec_o    (sec_o),
    .ns_o     (ns_o),
    .pps_o    (pps_o),
    .act_ns   (act_ns),
    .act_frac (act_frac)
);

// File: tb/tod_clock_unit_tb.sv
module tod_clock_unit_tb_top;
    localparam int unsigned NPS = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [47:0] sec_o;
    logic [29:0] ns_o;
    logic        pps_o;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    tod_clock_unit #(.NS_PER_SEC(NPS)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sec_o   (sec_o),
        .ns_o    (ns_o),
        .pps_o   (pps_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 sec after reset", 64'(sec_o), 64'd0);
        chk("R1 ns after reset", 64'(ns_o), 64'd0);
        chk("R1 pps after reset", 64'(pps_o), 64'd0);
        wait_cyc(5);
        chk("R2 ns frozen with zero step", 64'(ns_o), 64'd0);
    endtask

    task automatic t_staging();
        logic [31:0] d;
        wr(3'd3, 32'h1234_5678);
        wait_cyc(3);
        chk("R3 staged fraction not active", 64'(ns_o), 64'd0);
        rd(3'd3, d);
        chk("R10 staged fraction readback", 64'(d), 64'h1200_5678);
    endtask

    task automatic t_seconds();
        logic [31:0] d;
        wr(3'd0, 32'h0000_0001);
        chk("R6 high write no latch", 64'(sec_o), 64'd0);
        wr(3'd1, 32'h0000_0005);
        chk("R6 seconds load", 64'(sec_o), 64'h1_0000_0005);
        rd(3'd0, d);
        chk("R10 read seconds high", 64'(d), 64'h1);
        rd(3'd1, d);
        chk("R10 read seconds low", 64'(d), 64'h5);
    endtask

    task automatic t_whole_step();
        logic [31:0] d;
        wr(3'd3, 32'h0);
        wr(3'd4, 32'd10);
        wr(3'd2, 32'd100);
        chk("R7 ns load", 64'(ns_o), 64'd100);
        rd(3'd4, d);
        chk("R10 read active step", 64'(d), 64'd10);
        wait_cyc(3);
        chk("R4 whole step advance", 64'(ns_o), 64'd130);
    endtask

    task automatic t_fraction();
        wr(3'd3, 32'h0000_8000);
        wr(3'd4, 32'd1);
        wr(3'd2, 32'd0);
        wait_cyc(1);
        chk("R4 half fraction first tick", 64'(ns_o), 64'd1);
        wait_cyc(3);
        chk("R4 half fraction four ticks", 64'(ns_o), 64'd6);
    endtask

    task automatic t_rollover();
        logic [47:0] s;
        wr(3'd3, 32'h0);
        wr(3'd4, 32'd10);
        wr(3'd2, 32'd990);
        s = sec_o;
        chk("R9 no pps on ns load", 64'(pps_o), 64'd0);
        wait_cyc(1);
        chk("R5 ns wrap", 64'(ns_o), 64'd0);
        chk("R5 seconds carry", 64'(sec_o), 64'(s + 48'd1));
        chk("R9 pps on rollover", 64'(pps_o), 64'd1);
        wait_cyc(1);
        chk("R9 pps one cycle", 64'(pps_o), 64'd0);
        chk("R4 step after wrap", 64'(ns_o), 64'd10);
        wr(3'd0, 32'h1);
        wr(3'd1, 32'hFFFF_FFFF);
        chk("R9 no pps on seconds load", 64'(pps_o), 64'd0);
        wr(3'd2, 32'd995);
        wait_cyc(1);
        chk("R5 carry across 32-bit boundary", 64'(sec_o), 64'h2_0000_0000);
        chk("R5 ns after carry", 64'(ns_o), 64'd5);
    endtask

    task automatic t_offset();
        logic [47:0] s;
        wr(3'd3, 32'h0);
        wr(3'd4, 32'd0);
        wr(3'd2, 32'd500);
        s = sec_o;
        wr(3'd5, 32'd300);
        chk("R8 positive offset", 64'(ns_o), 64'd800);
        wr(3'd5, 32'd600);
        chk("R8 offset carry ns", 64'(ns_o), 64'd400);
        chk("R8 offset carry sec", 64'(sec_o), 64'(s + 48'd1));
        chk("R9 no pps on offset", 64'(pps_o), 64'd0);
        wr(3'd5, 32'h8000_0000 | 32'd900);
        chk("R8 negative offset borrow ns", 64'(ns_o), 64'd500);
        chk("R8 negative offset borrow sec", 64'(sec_o), 64'(s));
        wr(3'd5, 32'h8000_0000 | 32'd200);
        chk("R8 negative offset no borrow", 64'(ns_o), 64'd300);
        wait_cyc(2);
        chk("R2 frozen after offsets", 64'(ns_o), 64'd300);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_staging();
        t_seconds();
        t_whole_step();
        t_fraction();
        t_rollover();
        t_offset();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        report();
    end
endmodule